// File: doc/BRIEF.md
# Variable-Length Micro-Cycle Timer

This block paces a processor's micro-cycles from a fast reference clock. Each clock edge counts as one reference tick of a modelled delay line, nominally 30 ns. A micro-cycle runs either short (180 ns, six ticks) or long (240 ns, eight ticks). A select input chooses the length at the start of every cycle. Along the way the block raises one-tick strobes at three fixed tap points, 30, 90 and 120 ns after the cycle begins. It closes every cycle with a one-tick end pulse, and the next cycle starts on the tick that follows.

A bus transfer can stretch a cycle. If the transfer-inhibit request is high on the tick of the 120 ns tap, the cycle parks in a bus-wait state. It stays there until the slave-sync acknowledge is seen high, then picks up counting at the tick after that tap. The microcode sequencer uses the end pulse to fetch its next word, the tap strobes to clock its datapath, and the wait output to observe bus stalls.

Top module: `ucyc_timer`

## Requirements
- R1: With no bus wait, a short cycle lasts 6 ticks and a long cycle lasts 8 ticks, counted from the first tick of the cycle up to and including the tick that carries the end pulse.
- R2: `long_sel` is sampled only on the first tick of a cycle (tick 0). During ticks 1 onward its value has no effect on the current cycle's length.
- R3: `tap_o[0]` is high on tick 1 only and `tap_o[1]` is high on tick 3 only. Each is one tick wide. Tick 0 is the first tick of the cycle.
- R4: `cyc_end_o` is high for exactly one tick per cycle: tick 5 for a short cycle, tick 7 for a long one. The following tick is tick 0 of the next cycle.
- R5: If `xfer_inh` is high on tick 4, `bus_wait_o` is high from the next tick on.
- R6: While waiting, each tick with `slave_ack` low adds another wait tick. The wait tick on which `slave_ack` is high is the last one, and tick 5 follows it. A transfer whose acknowledge comes after D low wait ticks therefore lengthens the cycle by D+1 ticks.
- R7: `xfer_inh` on any tick other than tick 4, and `slave_ack` outside the wait state, have no effect on strobes, wait or cycle length.
- R8: `tap_o[2]` is high on tick 4 only, once per cycle. During wait ticks it stays low, as do the other strobes and the end pulse.
- R9: A synchronous reset puts the block at tick 0 of a short cycle with all outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference tick clock |
| rst | input | 1 | Synchronous active-high reset |
| long_sel | input | 1 | Selects a long cycle when high, sampled at tick 0 |
| xfer_inh | input | 1 | Transfer-inhibit request, sampled at the 120 ns tap |
| slave_ack | input | 1 | Slave-sync acknowledge that ends a bus wait |
| tap_o | output | 3 | Tap strobes for 30, 90 and 120 ns (bit 0, 1, 2) |
| cyc_end_o | output | 1 | One-tick pulse on the last tick of a cycle |
| bus_wait_o | output | 1 | High while the cycle is held for a bus transfer |

## Verification
The bench builds the block with its default timing: a 30 ns tick, cycles of 180 and 240 ns, taps at 30, 90 and 120 ns, and stretching enabled. This puts every tap, both end positions, the entry into the wait state and the resume point within a few ticks of each other. Random cycles mix the two lengths with acknowledge delays from zero to five ticks and random noise on inputs that should be ignored. Directed cases cover zero-delay acknowledges and a reset in mid-cycle.

// File: rtl/ucyc_pkg.sv
package ucyc_pkg;

   typedef enum logic {
      PH_RUN  = 1'b0,
      PH_WAIT = 1'b1
   } phase_e;

   // Converts a delay in ns into a tick index on the modelled line
   function automatic int ns_to_tick(input int ns, input int tick_ns);
      return ns / tick_ns;
   endfunction

   function automatic bit ns_aligned(input int ns, input int tick_ns);
      return (ns % tick_ns) == 0;
   endfunction

endpackage

// File: rtl/ucyc_len_latch.sv
module ucyc_len_latch #(
   parameter int CW         = 3,
   parameter int SHORT_LAST = 5,
   parameter int LONG_LAST  = 7
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          at_start,
   input  logic          long_sel,
   output logic          is_long,
   output logic [CW-1:0] last_pos
);

   localparam logic [CW-1:0] SHORT_END = CW'(SHORT_LAST);
   localparam logic [CW-1:0] LONG_END  = CW'(LONG_LAST);

   always_ff @(posedge clk) begin
      if (rst)
         is_long <= 1'b0;
      else if (at_start)
         is_long <= long_sel;
   end

   assign last_pos = is_long ? LONG_END : SHORT_END;

   // R2: selection frozen outside the first tick of a cycle
   p_sel_frozen_r2: assert property (@(posedge clk) disable iff (rst)
      !at_start |=> $stable(is_long));

endmodule

// File: rtl/ucyc_seq.sv
module ucyc_seq
   import ucyc_pkg::*;
#(
   parameter int CW         = 3,
   parameter int WAIT_POS   = 4,
   parameter bit STRETCH_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [CW-1:0] last_pos,
   input  logic          xfer_inh,
   input  logic          slave_ack,
   output logic [CW-1:0] pos,
   output phase_e        phase
);

   localparam logic [CW-1:0] HOLD_AT   = CW'(WAIT_POS);
   localparam logic [CW-1:0] RESUME_AT = CW'(WAIT_POS + 1);

   logic [CW-1:0] pos_n;
   phase_e        phase_n;

   generate
      if (STRETCH_EN) begin : g_stretch
         always_comb begin
            pos_n   = pos;
            phase_n = phase;
            if (phase == PH_WAIT) begin
               if (slave_ack) begin
                  phase_n = PH_RUN;
                  pos_n   = RESUME_AT;
               end
            end else if (pos == HOLD_AT && xfer_inh) begin
               phase_n = PH_WAIT;
            end else if (pos == last_pos) begin
               pos_n = '0;
            end else begin
               pos_n = pos + 1'b1;
            end
         end

         // R5: inhibit at the hold tap parks the cycle
         p_enter_wait_r5: assert property (@(posedge clk) disable iff (rst)
            (phase == PH_RUN && pos == HOLD_AT && xfer_inh) |=> (phase == PH_WAIT));

         // R6: no acknowledge keeps the cycle parked at the same tick
         p_hold_wait_r6: assert property (@(posedge clk) disable iff (rst)
            (phase == PH_WAIT && !slave_ack) |=> (phase == PH_WAIT && $stable(pos)));

         // R6: acknowledge resumes counting just past the hold tap
         p_resume_r6: assert property (@(posedge clk) disable iff (rst)
            (phase == PH_WAIT && slave_ack) |=> (phase == PH_RUN && pos == RESUME_AT));
      end else begin : g_plain
         always_comb begin
            phase_n = PH_RUN;
            pos_n   = (pos == last_pos) ? '0 : pos + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         pos   <= '0;
         phase <= PH_RUN;
      end else begin
         pos   <= pos_n;
         phase <= phase_n;
      end
   end

   // R4: the last running tick wraps to the cycle start
   p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_RUN && pos == last_pos) |=> (pos == '0));

   // R7: the counter never passes the end of a cycle
   p_in_range_r7: assert property (@(posedge clk) disable iff (rst)
      pos <= last_pos);

endmodule

// File: rtl/ucyc_taps.sv
module ucyc_taps
   import ucyc_pkg::*;
#(
   parameter int                  CW      = 3,
   parameter int                  NT      = 3,
   parameter logic [NT*CW-1:0]    TAP_VEC = '0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [CW-1:0] pos,
   input  phase_e        phase,
   input  logic [CW-1:0] last_pos,
   output logic [NT-1:0] tap_o,
   output logic          cyc_end_o
);

   logic running;
   assign running = (phase == PH_RUN);

   generate
      for (genvar i = 0; i < NT; i++) begin : g_tap
         localparam logic [CW-1:0] AT = TAP_VEC[i*CW +: CW];
         assign tap_o[i] = running && (pos == AT);

         // R3: each strobe lasts one tick
         p_tap_pulse_r3: assert property (@(posedge clk) disable iff (rst)
            tap_o[i] |=> !tap_o[i]);
      end
   endgenerate

   assign cyc_end_o = running && (pos == last_pos);

   // R4: the end pulse is one tick wide
   p_end_pulse_r4: assert property (@(posedge clk) disable iff (rst)
      cyc_end_o |=> !cyc_end_o);

   // R8: nothing strobes while the cycle is held
   p_quiet_wait_r8: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_WAIT) |-> (tap_o == '0 && !cyc_end_o));

endmodule

// File: rtl/ucyc_timer.sv
module ucyc_timer
   import ucyc_pkg::*;
#(
   parameter int TICK_NS    = 30,
   parameter int SHORT_NS   = 180,
   parameter int LONG_NS    = 240,
   parameter int TAP_A_NS   = 30,
   parameter int TAP_B_NS   = 90,
   parameter int TAP_C_NS   = 120,
   parameter bit STRETCH_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       long_sel,
   input  logic       xfer_inh,
   input  logic       slave_ack,
   output logic [2:0] tap_o,
   output logic       cyc_end_o,
   output logic       bus_wait_o
);

   localparam int NT         = 3;
   localparam int SHORT_T    = ns_to_tick(SHORT_NS, TICK_NS);
   localparam int LONG_T     = ns_to_tick(LONG_NS, TICK_NS);
   localparam int TAP_A      = ns_to_tick(TAP_A_NS, TICK_NS);
   localparam int TAP_B      = ns_to_tick(TAP_B_NS, TICK_NS);
   localparam int TAP_C      = ns_to_tick(TAP_C_NS, TICK_NS);
   localparam int CW         = (LONG_T > 2) ? $clog2(LONG_T) : 1;
   localparam logic [NT*CW-1:0] TAP_VEC = {CW'(TAP_C), CW'(TAP_B), CW'(TAP_A)};

   if (!ns_aligned(SHORT_NS, TICK_NS) || !ns_aligned(LONG_NS, TICK_NS) ||
       !ns_aligned(TAP_A_NS, TICK_NS) || !ns_aligned(TAP_B_NS, TICK_NS) ||
       !ns_aligned(TAP_C_NS, TICK_NS)) begin : g_bad_align
      $error("ucyc_timer: every delay must be a whole number of ticks");
   end
   if (!(TAP_A > 0 && TAP_A < TAP_B && TAP_B < TAP_C)) begin : g_bad_taps
      $error("ucyc_timer: taps must be distinct, rising and after tick 0");
   end
   if (!(SHORT_T > TAP_C + 1 && LONG_T >= SHORT_T)) begin : g_bad_len
      $error("ucyc_timer: cycles must extend past the last tap");
   end

   logic [CW-1:0] pos;
   logic [CW-1:0] last_pos;
   phase_e        phase;
   logic          is_long;

   ucyc_len_latch #(
      .CW(CW), .SHORT_LAST(SHORT_T - 1), .LONG_LAST(LONG_T - 1)
   ) u_len (
      .clk(clk), .rst(rst), .at_start(pos == '0 && phase == PH_RUN),
      .long_sel(long_sel), .is_long(is_long), .last_pos(last_pos)
   );

   ucyc_seq #(
      .CW(CW), .WAIT_POS(TAP_C), .STRETCH_EN(STRETCH_EN)
   ) u_seq (
      .clk(clk), .rst(rst), .last_pos(last_pos), .xfer_inh(xfer_inh),
      .slave_ack(slave_ack), .pos(pos), .phase(phase)
   );

   ucyc_taps #(
      .CW(CW), .NT(NT), .TAP_VEC(TAP_VEC)
   ) u_taps (
      .clk(clk), .rst(rst), .pos(pos), .phase(phase), .last_pos(last_pos),
      .tap_o(tap_o), .cyc_end_o(cyc_end_o)
   );

   assign bus_wait_o = (phase == PH_WAIT);

   // R9: a reset leaves every output low on the next tick
   p_reset_quiet_r9: assert property (@(posedge clk)
      rst |=> (tap_o == '0 && !cyc_end_o && !bus_wait_o));

   // R1: a long cycle ends only on its own last tick
   p_long_end_r1: assert property (@(posedge clk) disable iff (rst)
      (cyc_end_o && is_long) |-> (pos == CW'(LONG_T - 1)));

endmodule

// File: tb/ucyc_timer_test.sv
`timescale 1ns/1ps
module ucyc_timer_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       long_sel = 1'b0;
   logic       xfer_inh = 1'b0;
   logic       slave_ack = 1'b0;
   logic [2:0] tap;
   logic       cyc_end;
   logic       bus_wait;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #4 clk = ~clk;

   ucyc_timer uut (
      .clk(clk), .rst(rst), .long_sel(long_sel), .xfer_inh(xfer_inh),
      .slave_ack(slave_ack), .tap_o(tap), .cyc_end_o(cyc_end),
      .bus_wait_o(bus_wait)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int cyc_len(input bit lng, input bit inh, input int d);
      return (lng ? 8 : 6) + (inh ? d + 1 : 0);
   endfunction

   // Walks one cycle from tick 0; checks every tick at the falling edge
   task automatic run_cycle(input bit lng, input bit inh, input int d);
      int  k = 0;
      bit  w = 0;
      int  wc = 0;
      int  ticks = 0;
      int  last = lng ? 7 : 5;
      bit  fin = 0;
      while (!fin) begin
         chk("R3", "tap0", int'(tap[0]), int'(!w && k == 1));
         chk("R3", "tap1", int'(tap[1]), int'(!w && k == 3));
         chk("R8", "tap2", int'(tap[2]), int'(!w && k == 4));
         chk("R4", "end",  int'(cyc_end), int'(!w && k == last));
         chk("R5", "wait", int'(bus_wait), int'(w));
         ticks++;
         long_sel  = (k == 0 && !w) ? lng : 1'($urandom_range(0, 1)); // R2 noise
         xfer_inh  = (!w && k == 4) ? inh : 1'($urandom_range(0, 1)); // R7 noise
         slave_ack = w ? (wc == d) : 1'($urandom_range(0, 1));        // R7 noise
         @(posedge clk);
         @(negedge clk);
         if (w) begin
            if (wc == d) begin w = 0; k = 5; end
            else wc++;
         end else if (k == 4 && inh) begin
            w = 1;
         end else if (k == last) begin
            k = 0; fin = 1;
         end else begin
            k++;
         end
      end
      if (inh) chk("R6", "stretched length", ticks, cyc_len(lng, inh, d));
      else     chk("R1", "length", ticks, cyc_len(lng, inh, d));
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      void'($urandom(32'h1c0de));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R9", "reset taps", int'(tap), 0);
      chk("R9", "reset end", int'(cyc_end), 0);
      chk("R9", "reset wait", int'(bus_wait), 0);
      rst = 1'b0;

      run_cycle(0, 0, 0);   // R1 short
      run_cycle(1, 0, 0);   // R1 long
      run_cycle(0, 1, 0);   // R6 zero delay
      run_cycle(1, 1, 0);
      run_cycle(0, 1, 4);   // R6 several ticks
      run_cycle(1, 1, 4);
      run_cycle(1, 0, 0);
      run_cycle(0, 0, 0);   // R2 short after long

      for (int n = 0; n < 40; n++)
         run_cycle(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                   int'($urandom_range(0, 5)));

      // R9: reset in mid-cycle
      for (int n = 0; n < 3; n++) begin
         long_sel = 1'b1; xfer_inh = 1'b0; slave_ack = 1'b0;
         @(posedge clk);
         @(negedge clk);
      end
      chk("R3", "tap1 before reset", int'(tap), 2);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R9", "mid reset taps", int'(tap), 0);
      chk("R9", "mid reset end", int'(cyc_end), 0);
      chk("R9", "mid reset wait", int'(bus_wait), 0);
      rst = 1'b0;
      run_cycle(0, 0, 0);
      run_cycle(0, 1, 2);

      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

endmodule